// File: doc/BRIEF.md
# Railway Point Route Life-Cycle Controller

This block is the route-execution logic of a single railway point (switch) object in an interlocking. It follows one route over the point through its life cycle: it waits in Rest, then goes through Calling, Setting, Locking and Releasing, and returns to Rest. The point joins three track legs: channel 0 is the toe, channel 1 is the normal leg and channel 2 is the reverse leg. Two point positions and two travel directions give four route variants. Each variant has its own four stage states, and a neighbouring object sits on each channel.

The dispatcher requests a variant. A neighbour on the variant's entry channel signals readiness. The trackside controller reports the detected point position and track-circuit occupancy. The neighbour on the exit channel reports that the train has passed. Each step waits for exactly one condition and holds its state until that condition is true. The block drives a stage/variant indication code to the dispatcher, a position command to the trackside controller and per-channel busy flags to the neighbours. All outputs are decoded from a one-hot state register.

Variant table (entry channel, exit channel, position): V0 = (0, 1, normal), V1 = (1, 0, normal), V2 = (0, 2, reverse), V3 = (2, 0, reverse).

Top module: `point_route_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in Rest within one clock edge, from any state. In Rest, ind_code, pos_cmd and nb_busy are all zero.
- R2: In Rest, an active route_req bit moves the block to Calling of that variant at the next edge. When several bits are set, the lowest-numbered variant wins. ind_code is {variant[1:0], stage[2:0]}, with stage 0 = Rest, 1 = Calling, 2 = Setting, 3 = Locking and 4 = Releasing. In Rest the variant field is 0.
- R3: route_req has no effect in any state other than Rest.
- R4: Calling advances to Setting only when nb_ready on the variant's entry channel is 1. Otherwise it holds, whatever the other channels show.
- R5: Setting advances to Locking only when pos_det shows the variant's position. Bit 0 means normal (V0, V1) and bit 1 means reverse (V2, V3). Otherwise it holds.
- R6: Locking advances to Releasing when track_occ is 1. Otherwise it holds.
- R7: Releasing returns to Rest only when track_occ is 1 and nb_passed on the variant's exit channel is 1 in the same cycle. Otherwise it holds.
- R8: pos_cmd is zero in Rest and Calling. From Setting through Releasing it has exactly the variant's position bit set: bit 0 for normal, bit 1 for reverse.
- R9: Outside Rest, nb_busy has exactly the bits of the variant's entry and exit channels set. In Rest it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| route_req | input | 4 | Dispatcher request, one bit per variant |
| nb_ready | input | 3 | Neighbour readiness, one bit per channel |
| nb_passed | input | 3 | Neighbour reports train passed, one bit per channel |
| pos_det | input | 2 | Detected point position: bit 0 normal, bit 1 reverse |
| track_occ | input | 1 | Track circuit over the point is occupied |
| ind_code | output | 5 | {variant, stage} indication to the dispatcher |
| pos_cmd | output | 2 | Point position command: bit 0 normal, bit 1 reverse |
| nb_busy | output | 3 | Per-channel busy flags to the neighbours |

## Verification
Every cycle, the assertions check the following:
- the state register is one-hot;
- each stage either advances or holds on its own lane condition;
- Calling is entered only from Rest;
- the lowest request wins;
- the position command stays off before Setting.

Only the bench's scenarios can show certain behaviours. These are the choice of entry and exit channel for each variant, because the other channels are driven active in the same cycle. They also include ignoring requests in mid-route, which shows up as an unchanged indication, and reset out of the middle of a route.

// File: rtl/prc_pkg.sv
// Shared constants and variant geometry for the point route controller.
// Assumes a three-leg point: channel 0 toe, 1 normal leg, 2 reverse leg.
package prc_pkg;
    localparam int NV  = 4;             // route variants
    localparam int NST = 4;             // stages per variant
    localparam int NCH = 3;             // geographic channels
    localparam int NPOS = 2;            // point positions
    localparam int VW  = $clog2(NV);
    localparam int SW  = 1 + NV * NST;  // one-hot state width
    localparam int IW  = VW + 3;        // indication width

    localparam logic [2:0] IND_REST = 3'd0;
    localparam logic [2:0] IND_CALL = 3'd1;
    localparam logic [2:0] IND_SET  = 3'd2;
    localparam logic [2:0] IND_LOCK = 3'd3;
    localparam logic [2:0] IND_REL  = 3'd4;

    // Channel a train enters the point from for a variant.
    function automatic int entry_ch(input int v);
        case (v)
            1:       return 1;
            3:       return 2;
            default: return 0;
        endcase
    endfunction

    // Channel a train leaves the point by for a variant.
    function automatic int exit_ch(input int v);
        case (v)
            0:       return 1;
            2:       return 2;
            default: return 0;
        endcase
    endfunction

    // Position bit a variant needs: 0 normal, 1 reverse.
    function automatic int pos_bit(input int v);
        return v / 2;
    endfunction
endpackage

// File: rtl/prc_arbiter.sv
// Fixed-priority picker: the lowest set request bit wins.
// Assumes requests are sampled only while the caller is idle.
module prc_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan upward and keep the first set bit only.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // Any request pending.
    assign any = |req;
endmodule

// File: rtl/prc_lane.sv
// Next-stage logic for one route variant: Calling, Setting, Locking, Releasing.
// Assumes cur is this variant's slice of a one-hot register; each stage
// holds until its own single condition is true.
module prc_lane
    import prc_pkg::*;
#(
    parameter int VAR = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NST-1:0]  cur,
    input  logic            start,
    input  logic [NCH-1:0]  nb_ready,
    input  logic [NCH-1:0]  nb_passed,
    input  logic [NPOS-1:0] pos_det,
    input  logic            occupied,
    output logic [NST-1:0]  nxt,
    output logic            done
);
    localparam int ENT = entry_ch(VAR);
    localparam int EXT = exit_ch(VAR);
    localparam int PB  = pos_bit(VAR);

    logic rdy, at_pos, cleared;

    // Select this variant's conditions from the shared inputs.
    assign rdy     = nb_ready[ENT];
    assign at_pos  = pos_det[PB];
    assign cleared = occupied & nb_passed[EXT];

    // Advance or hold each stage on its one condition.
    always_comb begin
        nxt[0] = start  | (cur[0] & ~rdy);
        nxt[1] = (cur[0] & rdy)    | (cur[1] & ~at_pos);
        nxt[2] = (cur[1] & at_pos) | (cur[2] & ~occupied);
        nxt[3] = (cur[2] & occupied) | (cur[3] & ~cleared);
        done   = cur[3] & cleared;
    end

    assert_call_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[0] && !nb_ready[ENT]) |=> cur[0]);
    assert_call_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[0] && nb_ready[ENT]) |=> cur[1]);
    assert_set_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[1] && !pos_det[PB]) |=> cur[1]);
    assert_lock_adv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[2] && occupied) |=> cur[3]);
    assert_rel_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[3] && occupied && nb_passed[EXT]) |=> (cur == '0));
endmodule

// File: rtl/prc_decode.sv
// Output decoder: turns the one-hot state into indication, position
// command and neighbour busy flags. Assumes at most one state bit is set.
module prc_decode
    import prc_pkg::*;
(
    input  logic [SW-1:0]   state,
    output logic [IW-1:0]   ind_code,
    output logic [NPOS-1:0] pos_cmd,
    output logic [NCH-1:0]  nb_busy
);
    // OR together the outputs of whichever state bit is set.
    always_comb begin
        ind_code = '0;
        pos_cmd  = '0;
        nb_busy  = '0;
        for (int v = 0; v < NV; v++) begin
            for (int s = 0; s < NST; s++) begin
                if (state[1 + v*NST + s]) begin
                    ind_code = {VW'(v), 3'(s + 1)};
                    nb_busy[entry_ch(v)] = 1'b1;
                    nb_busy[exit_ch(v)]  = 1'b1;
                    if (s >= 1) pos_cmd[pos_bit(v)] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/point_route_ctrl.sv
// Route life-cycle controller for one point object. Holds a one-hot
// state (bit 0 = Rest, then four stages per variant), arbitrates requests
// in Rest, and decodes Moore outputs. Illegal encodings fall back to Rest.
module point_route_ctrl
    import prc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NV-1:0]   route_req,
    input  logic [NCH-1:0]  nb_ready,
    input  logic [NCH-1:0]  nb_passed,
    input  logic [NPOS-1:0] pos_det,
    input  logic            track_occ,
    output logic [IW-1:0]   ind_code,
    output logic [NPOS-1:0] pos_cmd,
    output logic [NCH-1:0]  nb_busy
);
    localparam logic [SW-1:0] REST_ST = SW'(1);

    logic [SW-1:0]      state_q, state_d;
    logic [NV-1:0]      grant, done;
    logic               any_req;
    logic [NV*NST-1:0]  lane_nxt;

    prc_arbiter #(.N(NV)) arb_i (
        .req   (route_req),
        .grant (grant),
        .any   (any_req)
    );

    for (genvar v = 0; v < NV; v++) begin : g_lane
        prc_lane #(.VAR(v)) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cur       (state_q[1 + v*NST +: NST]),
            .start     (state_q[0] & grant[v]),
            .nb_ready  (nb_ready),
            .nb_passed (nb_passed),
            .pos_det   (pos_det),
            .occupied  (track_occ),
            .nxt       (lane_nxt[v*NST +: NST]),
            .done      (done[v])
        );
    end

    // Assemble next state; any non-one-hot value recovers to Rest.
    always_comb begin
        if (!$onehot(state_q)) state_d = REST_ST;
        else state_d = {lane_nxt, (state_q[0] & ~any_req) | (|done)};
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= REST_ST;
        else        state_q <= state_d;
    end

    prc_decode dec_i (
        .state    (state_q),
        .ind_code (ind_code),
        .pos_cmd  (pos_cmd),
        .nb_busy  (nb_busy)
    );

    assert_reset_rest_R1: assert property (@(posedge clk)
        !rst_n |=> (ind_code == '0 && pos_cmd == '0 && nb_busy == '0));
    assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q));
    assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q[0] && route_req[0]) |=> (ind_code == {VW'(0), IND_CALL}));
    assert_call_from_rest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_code[2:0] == IND_CALL && $past(ind_code[2:0]) != IND_CALL)
            |-> $past(ind_code[2:0]) == IND_REST);
    assert_cmd_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_code[2:0] <= IND_CALL) |-> (pos_cmd == '0));
endmodule

// File: tb/point_route_ctrl_tb_top.sv
module point_route_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] route_req;
    logic [2:0] nb_ready, nb_passed;
    logic [1:0] pos_det;
    logic       track_occ;
    logic [4:0] ind_code;
    logic [1:0] pos_cmd;
    logic [2:0] nb_busy;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    point_route_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .route_req(route_req), .nb_ready(nb_ready),
        .nb_passed(nb_passed), .pos_det(pos_det), .track_occ(track_occ),
        .ind_code(ind_code), .pos_cmd(pos_cmd), .nb_busy(nb_busy)
    );

    function automatic int ent_of(input int v);
        return (v == 1) ? 1 : (v == 3) ? 2 : 0;
    endfunction
    function automatic int ext_of(input int v);
        return (v == 0) ? 1 : (v == 2) ? 2 : 0;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        route_req = '0; nb_ready = '0; nb_passed = '0; pos_det = '0; track_occ = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Check all outputs against variant v at stage stg (0 = Rest).
    task automatic expect_st(input string tag, input int v, input int stg);
        int e_ind, e_cmd, e_busy;
        e_ind  = (stg == 0) ? 0 : (v * 8 + stg);
        e_cmd  = (stg >= 2) ? (1 << (v / 2)) : 0;
        e_busy = (stg == 0) ? 0 : ((1 << ent_of(v)) | (1 << ext_of(v)));
        chk(tag, int'(ind_code), e_ind);
        chk({tag, " R8 pos_cmd"}, int'(pos_cmd), e_cmd);
        chk({tag, " R9 nb_busy"}, int'(nb_busy), e_busy);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        tick(); tick();
        expect_st("R1 reset state", 0, 0);
        rst_n = 1'b1;
        for (int v = 0; v < 4; v++) begin
            idle(); tick();
            expect_st("R2 rest without request", v, 0);
            route_req = 4'(4'hF << v);               // lowest set bit is v
            tick(); expect_st("R2 priority to Calling", v, 1);
            route_req = 4'hF;                         // R3 ignored from here on
            nb_ready  = 3'(3'h7 & ~(3'(1) << ent_of(v)));
            pos_det = 2'b11; track_occ = 1'b1; nb_passed = 3'h7;
            tick(); expect_st("R4 hold without entry ready, R3 req ignored", v, 1);
            idle(); route_req = 4'hF;
            nb_ready = 3'(1) << ent_of(v);
            tick(); expect_st("R4 advance to Setting", v, 2);
            nb_ready = '0;
            pos_det = 2'(1) << (1 - v / 2);
            tick(); expect_st("R5 hold on wrong position", v, 2);
            pos_det = 2'(1) << (v / 2);
            tick(); expect_st("R5 advance to Locking", v, 3);
            tick(); expect_st("R6 hold while clear", v, 3);
            track_occ = 1'b1;
            tick(); expect_st("R6 advance to Releasing", v, 4);
            nb_passed = 3'(3'h7 & ~(3'(1) << ext_of(v)));
            tick(); expect_st("R7 hold on wrong exit channel", v, 4);
            track_occ = 1'b0; nb_passed = 3'(1) << ext_of(v);
            tick(); expect_st("R7 hold without occupancy", v, 4);
            track_occ = 1'b1; route_req = '0;
            tick(); expect_st("R7 return to Rest", v, 0);
        end
        // Reset from mid-route.
        idle(); route_req = 4'b0100;
        tick(); idle();
        nb_ready = 3'b001; tick();
        pos_det = 2'b10; tick();
        expect_st("R1 setup reached Locking", 2, 3);
        rst_n = 1'b0; tick();
        expect_st("R1 reset from Locking", 2, 0);
        rst_n = 1'b1; idle(); tick();
        expect_st("R1 rest after reset", 2, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule